// File: doc/BRIEF.md
# Packed SIMD Saturating DSP Datapath

This block is the integer arithmetic datapath of a small signal-processing core. Each cycle it takes two 32-bit operands, a 64-bit accumulator value and a 3-bit operation code. For the add family it returns a 32-bit word. It can treat that word as one 32-bit value, two independent 16-bit lanes or four independent 8-bit lanes, and it can either wrap or clamp each lane to its signed range. For the multiply-accumulate family it returns a new 64-bit accumulator value. That value is formed from either one signed 32x32 product or the sum of two signed 16x16 half-word products.

Results are purely combinational, so every operation finishes in the cycle in which it is presented. The only state is a sticky clamp indicator. It records that some lane has clamped since the last clear, so software can test one flag after a whole loop of saturating adds.

Top module: `simd_dsp_alu`

## Requirements
- R1: Code 0 adds the two 32-bit operands modulo 2^32 and places the sum on `res_word`.
- R2: Code 1 adds bits [15:0] of the operands into `res_word[15:0]` and bits [31:16] into `res_word[31:16]`, each modulo 2^16, with no carry between the halves.
- R3: Code 2 adds byte lane i (bits [8i+7:8i], i = 0..3) of the operands into the same byte of `res_word`, modulo 2^8, and no carry crosses a lane.
- R4: Code 3 uses the lane split of R2 as signed values. A lane sum above 0x7FFF gives 0x7FFF, and one below -0x8000 gives 0x8000.
- R5: Code 4 uses the lane split of R3 as signed values. A lane sum above 0x7F gives 0x7F, and one below -0x80 gives 0x80.
- R6: Code 5 sets `acc_out` = `acc_in` + (signed `src_a` x signed `src_b`), modulo 2^64.
- R7: Code 6 sets `acc_out` = `acc_in` + a_lo x b_lo + a_hi x b_hi, modulo 2^64. Here lo/hi are bits [15:0]/[31:16] of each operand, taken as signed, and each product is sign-extended to 64 bits.
- R8: Outputs follow the inputs in the same cycle. `res_word` is 0 for codes 5, 6 and 7. `acc_out` equals `acc_in` for codes 0 to 4 and 7.
- R9: `sat_hit` is high only in a cycle where code 3 or 4 clamps at least one lane. Codes 0, 1, 2, 5, 6 and 7 never raise it, even on overflow.
- R10: `sat_sticky` goes high at the clock edge after a cycle with `sat_hit` high. It then stays high until an edge at which `sat_clr` is high and `sat_hit` is low. A clamp in the same cycle as a clear leaves the flag set.
- R11: While `rst_n` is low, `sat_sticky` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_sel | input | 3 | Operation code (0..6; 7 is no operation) |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| acc_in | input | 64 | Accumulator input |
| sat_clr | input | 1 | Clears the sticky clamp flag |
| res_word | output | 32 | Result of the add family |
| acc_out | output | 64 | Accumulator result |
| sat_hit | output | 1 | A lane clamped in this cycle |
| sat_sticky | output | 1 | A lane has clamped since the last clear |

## Verification
The assertions check several properties on every cycle. These are the flag sequencing (set after a clamp, hold, clear, set winning over clear), the rule that wrapping and multiply codes never report a clamp, and the pass-through and zeroing of the unused output. They also check that a reported clamp in a halfword mode always shows a rail value on the output. The lane arithmetic itself, carry isolation between lanes, correct clamp polarity and the sign extension of the products can only be shown by the bench's operand vectors, which are chosen to sit exactly at lane boundaries.

// File: rtl/simd_dsp_pkg.sv
package simd_dsp_pkg;

  localparam int WORD_W = 32;
  localparam int ACC_W  = 64;
  localparam int HALF_W = WORD_W / 2;
  localparam int BYTE_W = WORD_W / 4;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD32   = 3'd0,
    OP_ADD16X2 = 3'd1,
    OP_ADD8X4  = 3'd2,
    OP_QADD16  = 3'd3,
    OP_QADD8   = 3'd4,
    OP_MAC32   = 3'd5,
    OP_DMAC16  = 3'd6,
    OP_NONE    = 3'd7
  } dsp_op_e;

  // Signed full-word product added to the accumulator, wrapping modulo 2^ACC_W.
  function automatic logic [ACC_W-1:0] mac_word(input logic [ACC_W-1:0]  acc,
                                                input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b);
    logic signed [ACC_W-1:0] xa, xb;
    xa = {{(ACC_W-WORD_W){a[WORD_W-1]}}, a};
    xb = {{(ACC_W-WORD_W){b[WORD_W-1]}}, b};
    return acc + ACC_W'(xa * xb);
  endfunction

  // Sign-extended product of two signed half words.
  function automatic logic [ACC_W-1:0] half_prod(input logic [HALF_W-1:0] a,
                                                 input logic [HALF_W-1:0] b);
    logic signed [ACC_W-1:0] xa, xb;
    xa = {{(ACC_W-HALF_W){a[HALF_W-1]}}, a};
    xb = {{(ACC_W-HALF_W){b[HALF_W-1]}}, b};
    return ACC_W'(xa * xb);
  endfunction

  function automatic logic [ACC_W-1:0] mac_dual(input logic [ACC_W-1:0]  acc,
                                                input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b);
    return acc + half_prod(a[HALF_W-1:0], b[HALF_W-1:0])
               + half_prod(a[WORD_W-1:HALF_W], b[WORD_W-1:HALF_W]);
  endfunction

endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter  int WORD_W = 32,
  parameter  int LANE_W = 16,
  localparam int LANES  = WORD_W / LANE_W
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              sat_en,
  output logic [WORD_W-1:0] sum,
  output logic [LANES-1:0]  lane_clamp
);

  localparam logic [LANE_W-1:0] POS_RAIL = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] NEG_RAIL = {1'b1, {(LANE_W-1){1'b0}}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb, raw;
    logic              ovf;
    assign la  = a[g*LANE_W +: LANE_W];
    assign lb  = b[g*LANE_W +: LANE_W];
    assign raw = la + lb;
    // Signed overflow: operands agree in sign, the wrapped sum does not.
    assign ovf = (la[LANE_W-1] == lb[LANE_W-1]) && (raw[LANE_W-1] != la[LANE_W-1]);
    assign lane_clamp[g] = sat_en && ovf;
    assign sum[g*LANE_W +: LANE_W] =
      lane_clamp[g] ? (la[LANE_W-1] ? NEG_RAIL : POS_RAIL) : raw;
  end

endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
  import simd_dsp_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [ACC_W-1:0]  acc,
  input  logic              dual,
  output logic [ACC_W-1:0]  acc_next
);

  logic [ACC_W-1:0] single_sum, dual_sum;

  assign single_sum = mac_word(acc, a, b);
  assign dual_sum   = mac_dual(acc, a, b);
  assign acc_next   = dual ? dual_sum : single_sum;

endmodule

// File: rtl/simd_sat_flag.sv
module simd_sat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic sticky
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= 1'b0;
    else        sticky <= (sticky && !clr) || hit;
  end

endmodule

// File: rtl/simd_dsp_alu.sv
module simd_dsp_alu
  import simd_dsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic              sat_clr,
  output logic [WORD_W-1:0] res_word,
  output logic [ACC_W-1:0]  acc_out,
  output logic              sat_hit,
  output logic              sat_sticky
);

  localparam int LANES16 = WORD_W / HALF_W;
  localparam int LANES8  = WORD_W / BYTE_W;

  dsp_op_e op;
  assign op = dsp_op_e'(op_sel);

  logic                q16_sel, q8_sel, mac_sel;
  logic [WORD_W-1:0]   sum32, sum16, sum8, mac_unused_word;
  logic [0:0]          clamp32;
  logic [LANES16-1:0]  clamp16;
  logic [LANES8-1:0]   clamp8;
  logic [ACC_W-1:0]    mac_acc;

  assign q16_sel = (op == OP_QADD16);
  assign q8_sel  = (op == OP_QADD8);
  assign mac_sel = (op == OP_MAC32) || (op == OP_DMAC16);
  assign mac_unused_word = '0;

  simd_lane_adder #(.WORD_W(WORD_W), .LANE_W(WORD_W)) u_add32 (
    .a(src_a), .b(src_b), .sat_en(1'b0), .sum(sum32), .lane_clamp(clamp32)
  );

  simd_lane_adder #(.WORD_W(WORD_W), .LANE_W(HALF_W)) u_add16 (
    .a(src_a), .b(src_b), .sat_en(q16_sel), .sum(sum16), .lane_clamp(clamp16)
  );

  simd_lane_adder #(.WORD_W(WORD_W), .LANE_W(BYTE_W)) u_add8 (
    .a(src_a), .b(src_b), .sat_en(q8_sel), .sum(sum8), .lane_clamp(clamp8)
  );

  simd_mac_unit u_mac (
    .a(src_a), .b(src_b), .acc(acc_in), .dual(op == OP_DMAC16), .acc_next(mac_acc)
  );

  always_comb begin
    unique case (op)
      OP_ADD32:               res_word = sum32;
      OP_ADD16X2, OP_QADD16:  res_word = sum16;
      OP_ADD8X4,  OP_QADD8:   res_word = sum8;
      default:                res_word = mac_unused_word;
    endcase
  end

  assign acc_out = mac_sel ? mac_acc : acc_in;
  assign sat_hit = (|clamp32) || (|clamp16) || (|clamp8);

  simd_sat_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(sat_hit), .clr(sat_clr), .sticky(sat_sticky)
  );

endmodule

// File: rtl/simd_dsp_alu_chk.sv
module simd_dsp_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op_sel,
  input logic [63:0] acc_in,
  input logic        sat_clr,
  input logic [31:0] res_word,
  input logic [63:0] acc_out,
  input logic        sat_hit,
  input logic        sat_sticky,
  input logic [1:0]  clamp16
);

  // R10: a clamp is recorded at the next edge, whatever sat_clr does
  a_r10_set_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |=> sat_sticky);

  // R10: clear without a concurrent clamp drops the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !sat_hit) |=> !sat_sticky);

  // R10: without clear the flag holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !sat_clr) |=> sat_sticky);

  // R10: the flag never rises without a clamp
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_sticky && !sat_hit) |=> !sat_sticky);

  // R9: wrapping and multiply codes never report a clamp
  a_r9_wrap_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel != 3'd3 && op_sel != 3'd4) |-> !sat_hit);

  // R8: multiply and no-op codes zero the word result
  a_r8_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= 3'd5) |-> (res_word == 32'h0));

  // R8: non-multiply codes pass the accumulator through
  a_r8_acc_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel <= 3'd4 || op_sel == 3'd7) |-> (acc_out == acc_in));

  // R4: a clamped low half-lane shows one of the two rails
  a_r4_rail_low: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd3 && clamp16[0]) |->
      (res_word[15:0] == 16'h7FFF || res_word[15:0] == 16'h8000));

  // R4: a clamped high half-lane shows one of the two rails
  a_r4_rail_high: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd3 && clamp16[1]) |->
      (res_word[31:16] == 16'h7FFF || res_word[31:16] == 16'h8000));

endmodule

bind simd_dsp_alu simd_dsp_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_in(acc_in), .sat_clr(sat_clr),
  .res_word(res_word), .acc_out(acc_out), .sat_hit(sat_hit),
  .sat_sticky(sat_sticky), .clamp16(clamp16)
);

// File: tb/simd_dsp_alu_tb.sv
module simd_dsp_alu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] acc;
    logic [31:0] res;
    logic [63:0] accx;
    logic        hit;
  } vec_t;

  localparam vec_t VT [NVEC] = '{
    '{8'd1, 3'd0, 32'hFFFFFFFF, 32'h00000002, 64'h1111, 32'h00000001, 64'h1111, 1'b0}, // R1 wrap
    '{8'd1, 3'd0, 32'h7FFFFFFF, 32'h00000001, 64'h0,    32'h80000000, 64'h0,    1'b0}, // R1 no clamp
    '{8'd2, 3'd1, 32'h0001FFFF, 32'h00010001, 64'h22,   32'h00020000, 64'h22,   1'b0}, // R2 no carry
    '{8'd2, 3'd1, 32'h7FFF8000, 32'h00018000, 64'h0,    32'h80000000, 64'h0,    1'b0}, // R2 wrap
    '{8'd3, 3'd2, 32'hFF7F0180, 32'h0101FF80, 64'h0,    32'h00800000, 64'h0,    1'b0}, // R3 lanes
    '{8'd4, 3'd3, 32'h7FFF8000, 32'h00018000, 64'h0,    32'h7FFF8000, 64'h0,    1'b1}, // R4 both rails
    '{8'd4, 3'd3, 32'h12340005, 32'h1111FFFE, 64'h0,    32'h23450003, 64'h0,    1'b0}, // R4 in range
    '{8'd5, 3'd4, 32'h7F80407F, 32'h01FF4001, 64'h0,    32'h7F807F7F, 64'h0,    1'b1}, // R5 clamps
    '{8'd5, 3'd4, 32'h10F0FF05, 32'h20F00203, 64'h0,    32'h30E00108, 64'h0,    1'b0}, // R5 in range
    '{8'd6, 3'd5, 32'hFFFFFFFF, 32'h00000003, 64'h10,   32'h0, 64'h000000000000000D, 1'b0}, // R6 signed
    '{8'd6, 3'd5, 32'h80000000, 32'h80000000, 64'h4000000000000000, 32'h0,
      64'h8000000000000000, 1'b0},                                                      // R6 wrap 2^64
    '{8'd7, 3'd6, 32'h0003FFFE, 32'h00040005, 64'hFFFFFFFFFFFFFFFF, 32'h0, 64'h1, 1'b0}, // R7 mixed sign
    '{8'd7, 3'd6, 32'h80008000, 32'h80008000, 64'h0, 32'h0, 64'h0000000080000000, 1'b0}, // R7 extension
    '{8'd8, 3'd7, 32'h00000001, 32'h00000001, 64'h55, 32'h0, 64'h55, 1'b0}            // R8 no-op
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic [63:0] acc_in;
  logic        sat_clr;
  logic [31:0] res_word;
  logic [63:0] acc_out;
  logic        sat_hit, sat_sticky;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_dsp_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .sat_clr(sat_clr), .res_word(res_word), .acc_out(acc_out),
    .sat_hit(sat_hit), .sat_sticky(sat_sticky)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [63:0] acc, input logic clr);
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; acc_in = acc; sat_clr = clr;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_sel = 3'd0; src_a = '0; src_b = '0; acc_in = '0; sat_clr = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R11 reset", 64'(sat_sticky), 64'h0);
    @(negedge clk) rst_n = 1'b1;

    // Table walk: same-cycle results (R1..R9 per vector tag)
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      drive(VT[i].op, VT[i].a, VT[i].b, VT[i].acc, 1'b1);
      tag = $sformatf("R%0d vec%0d", VT[i].req, i);
      check({tag, " word"}, 64'(res_word), 64'(VT[i].res));
      check({tag, " acc"}, acc_out, VT[i].accx);
      check({tag, " R9 hit"}, 64'(sat_hit), 64'(VT[i].hit));
    end

    // R10: clear, then a clamp sets the flag
    drive(3'd0, 32'h0, 32'h0, 64'h0, 1'b1);
    @(posedge clk); #1;
    check("R10 cleared", 64'(sat_sticky), 64'h0);
    drive(3'd4, 32'h0000007F, 32'h00000001, 64'h0, 1'b0);
    @(posedge clk); #1;
    check("R10 set", 64'(sat_sticky), 64'h1);
    // R10: holds across a non-clamping op
    drive(3'd1, 32'h1, 32'h1, 64'h0, 1'b0);
    @(posedge clk); #1;
    check("R10 hold", 64'(sat_sticky), 64'h1);
    // R10: clear drops it
    drive(3'd1, 32'h1, 32'h1, 64'h0, 1'b1);
    @(posedge clk); #1;
    check("R10 clear", 64'(sat_sticky), 64'h0);
    // R10: clamp and clear together, set wins
    drive(3'd3, 32'h80000000, 32'h80000000, 64'h0, 1'b1);
    check("R4 high negative rail", 64'(res_word), 64'h80000000);
    @(posedge clk); #1;
    check("R10 set wins", 64'(sat_sticky), 64'h1);
    // R9: overflow in wrapping codes leaves the flag untouched
    drive(3'd0, 32'h0, 32'h0, 64'h0, 1'b1);
    @(posedge clk); #1;
    drive(3'd1, 32'h7FFF7FFF, 32'h00010001, 64'h0, 1'b0);
    @(posedge clk); #1;
    drive(3'd2, 32'h7F7F7F7F, 32'h01010101, 64'h0, 1'b0);
    check("R3 all lanes wrap", 64'(res_word), 64'h80808080);
    @(posedge clk); #1;
    drive(3'd5, 32'h7FFFFFFF, 32'h7FFFFFFF, 64'h7FFFFFFFFFFFFFFF, 1'b0);
    check("R6 large", acc_out, 64'h3FFFFFFF00000000 + 64'h7FFFFFFFFFFFFFFF + 64'h1);
    @(posedge clk); #1;
    check("R9 wrap no flag", 64'(sat_sticky), 64'h0);
    // R11: reset clears a set flag
    drive(3'd4, 32'h80, 32'h80, 64'h0, 1'b0);
    check("R5 negative rail", 64'(res_word), 64'h00000080);
    @(posedge clk); #1;
    check("R10 set again", 64'(sat_sticky), 64'h1);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R11 async reset", 64'(sat_sticky), 64'h0);
    @(negedge clk) rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule